// File: doc/BRIEF.md
# Quadrature Encoder Position and Index Counter

This block turns the two phase signals of an incremental encoder and its once-per-revolution marker into a signed position count and an index-event count. It also keeps the direction of the last counted step. The phase and marker pins are asynchronous. Each one passes through a two-stage synchroniser before any edge is decoded, so every pin change reaches the counters on the third rising clock edge after it occurs.

A two-bit source select picks the counting source:
- four-times quadrature decoding of the two phases;
- an external clock on phase A, with phase B giving the direction;
- an internal timer that counts every clock cycle;
- hold, which stops counting.

A polarity input reverses the counting direction. A three-bit position-mode field set to the modulo value makes the position wrap between a low-limit and a high-limit input. Reversing the polarity never swaps the roles of the two limits.

All pins are plain control and status signals. The block has no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `qenc_counter`

## Requirements
- R1: After reset, the position count and the index count are zero, the direction output is 1 (positive), and the error flag is 0.
- R2: With source select 2'b00 (quadrature), each single-phase change of {A,B} along the sequence 00→10→11→01→00 adds one to the position, and the reverse sequence subtracts one. The direction output follows the last step. The new count appears on the third rising clock edge after the pin change.
- R3: In quadrature mode, a change of both phases at once leaves the position unchanged and sets the error flag. The flag stays set until reset.
- R4: When the polarity input is 1, every decoded step counts in the opposite direction, and the direction output shows the inverted direction.
- R5: When the position-mode field is 3'b110 and a step counts upward from a position at or above the high limit, the position is loaded with the low limit.
- R6: When the position-mode field is 3'b110 and a step counts downward from a position at or below the low limit, the position is loaded with the high limit. This holds with either polarity.
- R7: A rising edge on the index input adds one to the index count when the stored direction is positive.
- R8: A rising edge on the index input subtracts one from the index count only when the stored direction is negative.
- R9: With source select 2'b01 (external clock), each rising edge of A counts one step. The step is upward when B is 0 and downward when B is 1. Falling edges of A and changes of B alone do not count.
- R10: With source select 2'b10 (internal timer), the position rises by one on every clock cycle while the polarity is 0.
- R11: With source select 2'b11 (hold), the position does not change, whatever the phase inputs do.
- R12: With any position-mode value other than 3'b110, the position wraps modulo 2^POS_W. One step down from zero gives all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Phase A, asynchronous |
| enc_b | input | 1 | Phase B, asynchronous |
| enc_idx | input | 1 | Index marker, asynchronous |
| cfg_src | input | 2 | Counting source: 00 quadrature, 01 external clock, 10 timer, 11 hold |
| cfg_pos_mode | input | 3 | Position mode; 3'b110 selects modulo wrap |
| cfg_invert | input | 1 | Reverses the counting direction |
| lim_lo | input | POS_W | Signed low limit for modulo mode |
| lim_hi | input | POS_W | Signed high limit for modulo mode |
| pos_count | output | POS_W | Signed position count |
| idx_count | output | IDX_W | Signed index-event count |
| dir_up | output | 1 | 1 when the last counted step was upward |
| err_flag | output | 1 | Sticky flag for an illegal quadrature transition |

## Verification
On every cycle, the checker enforces the following:
- the position moves by at most one count outside modulo mode;
- in modulo mode, a position inside the limits stays inside them;
- hold mode freezes the position;
- each index count change agrees with the stored direction;
- the error flag never clears.

Only the directed scenarios can show the exact Gray-code direction and the three-edge latency. They also show that an illegal transition is dropped and not counted, and which limit is loaded at each wrap, including under reversed polarity. The external-clock and timer counting rates are likewise shown only by the scenarios.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic [1:0] {
    SRC_QUAD   = 2'b00,
    SRC_EXTCLK = 2'b01,
    SRC_TIMER  = 2'b10,
    SRC_HOLD   = 2'b11
  } cnt_src_e;

  localparam logic [2:0] POS_MODE_MODULO = 3'b110;

  typedef struct packed {
    logic en;
    logic up;
  } step_t;

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_async,
  output logic [N-1:0] q_sync
);

  logic [N-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a,
  input  logic       b,
  input  logic       idx,
  input  logic [1:0] src,
  input  logic       invert,
  output step_t      step,
  output logic       idx_edge,
  output logic       err_flag
);

  logic prev_a, prev_b, prev_idx;
  logic a_chg, b_chg;
  logic raw_en, raw_up, illegal;
  logic err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_a   <= 1'b0;
      prev_b   <= 1'b0;
      prev_idx <= 1'b0;
    end else begin
      prev_a   <= a;
      prev_b   <= b;
      prev_idx <= idx;
    end
  end

  assign a_chg = a ^ prev_a;
  assign b_chg = b ^ prev_b;

  always_comb begin
    raw_en  = 1'b0;
    raw_up  = 1'b1;
    illegal = 1'b0;
    unique case (cnt_src_e'(src))
      SRC_QUAD: begin
        // exactly one phase moved: a legal Gray step
        raw_en  = a_chg ^ b_chg;
        // direction from the new A against the old B
        raw_up  = a ^ prev_b;
        illegal = a_chg & b_chg;
      end
      SRC_EXTCLK: begin
        raw_en = a & ~prev_a;
        raw_up = ~b;
      end
      SRC_TIMER: begin
        raw_en = 1'b1;
        raw_up = 1'b1;
      end
      SRC_HOLD: begin
        raw_en = 1'b0;
      end
      default: raw_en = 1'b0;
    endcase
  end

  assign step.en  = raw_en;
  assign step.up  = raw_up ^ invert;
  assign idx_edge = idx & ~prev_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (illegal) err_q <= 1'b1;
  end

  assign err_flag = err_q;

endmodule

// File: rtl/qenc_poscnt.sv
module qenc_poscnt
  import qenc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  step_t               step,
  input  logic                modulo_en,
  input  logic signed [W-1:0] lo,
  input  logic signed [W-1:0] hi,
  output logic signed [W-1:0] pos
);

  localparam logic signed [W-1:0] ONE = W'(1);

  logic signed [W-1:0] pos_q, pos_d;
  logic at_top, at_bot;

  assign at_top = (pos_q >= hi);
  assign at_bot = (pos_q <= lo);

  always_comb begin
    pos_d = pos_q;
    if (step.en) begin
      if (modulo_en && step.up && at_top)        pos_d = lo;
      else if (modulo_en && !step.up && at_bot)  pos_d = hi;
      else if (step.up)                          pos_d = pos_q + ONE;
      else                                       pos_d = pos_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos = pos_q;

endmodule

// File: rtl/qenc_idxcnt.sv
module qenc_idxcnt
  import qenc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  step_t               step,
  input  logic                idx_edge,
  output logic signed [W-1:0] idx,
  output logic                dir_up
);

  localparam logic signed [W-1:0] ONE = W'(1);

  logic                dir_q;
  logic signed [W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dir_q <= 1'b1;
    else if (step.en) dir_q <= step.up;
  end

  // index counting uses the direction held before this cycle's step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             idx_q <= '0;
    else if (idx_edge) begin
      if (dir_q)            idx_q <= idx_q + ONE;
      else                  idx_q <= idx_q - ONE;
    end
  end

  assign idx    = idx_q;
  assign dir_up = dir_q;

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int POS_W       = 16,
  parameter int IDX_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enc_a,
  input  logic                    enc_b,
  input  logic                    enc_idx,
  input  logic [1:0]              cfg_src,
  input  logic [2:0]              cfg_pos_mode,
  input  logic                    cfg_invert,
  input  logic signed [POS_W-1:0] lim_lo,
  input  logic signed [POS_W-1:0] lim_hi,
  output logic signed [POS_W-1:0] pos_count,
  output logic signed [IDX_W-1:0] idx_count,
  output logic                    dir_up,
  output logic                    err_flag
);

  localparam int NPINS = 3;

  logic [NPINS-1:0] pins_sync;
  step_t            step;
  logic             idx_edge;
  logic             modulo_en;

  qenc_sync #(.N(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({enc_idx, enc_b, enc_a}),
    .q_sync  (pins_sync)
  );

  qenc_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .a        (pins_sync[0]),
    .b        (pins_sync[1]),
    .idx      (pins_sync[2]),
    .src      (cfg_src),
    .invert   (cfg_invert),
    .step     (step),
    .idx_edge (idx_edge),
    .err_flag (err_flag)
  );

  assign modulo_en = (cfg_pos_mode == POS_MODE_MODULO);

  qenc_poscnt #(.W(POS_W)) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .modulo_en (modulo_en),
    .lo        (lim_lo),
    .hi        (lim_hi),
    .pos       (pos_count)
  );

  qenc_idxcnt #(.W(IDX_W)) u_idx (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .idx_edge (idx_edge),
    .idx      (idx_count),
    .dir_up   (dir_up)
  );

endmodule

// File: rtl/qenc_counter_chk.sv
module qenc_counter_chk #(
  parameter int POS_W = 16,
  parameter int IDX_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              cfg_src,
  input logic [2:0]              cfg_pos_mode,
  input logic signed [POS_W-1:0] lim_lo,
  input logic signed [POS_W-1:0] lim_hi,
  input logic signed [POS_W-1:0] pos_count,
  input logic signed [IDX_W-1:0] idx_count,
  input logic                    dir_up,
  input logic                    err_flag
);

  logic signed [POS_W-1:0] pos_prev, lo_q, hi_q, pos_delta;
  logic signed [IDX_W-1:0] idx_prev, idx_delta;
  logic dir_prev, err_prev, mod_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_prev <= '0;
      idx_prev <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      dir_prev <= 1'b1;
      err_prev <= 1'b0;
      mod_q    <= 1'b0;
      hold_q   <= 1'b0;
    end else begin
      pos_prev <= pos_count;
      idx_prev <= idx_count;
      lo_q     <= lim_lo;
      hi_q     <= lim_hi;
      dir_prev <= dir_up;
      err_prev <= err_flag;
      mod_q    <= (cfg_pos_mode == 3'b110);
      hold_q   <= (cfg_src == 2'b11);
    end
  end

  assign pos_delta = pos_count - pos_prev;
  assign idx_delta = idx_count - idx_prev;

  assert_pos_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_q |-> (pos_delta == '0 || pos_delta == POS_W'(1) || pos_delta == '1));

  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_prev |-> err_flag);

  assert_modulo_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_q && lo_q <= hi_q && pos_prev >= lo_q && pos_prev <= hi_q)
      |-> (pos_count >= lo_q && pos_count <= hi_q));

  assert_idx_up_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_delta == IDX_W'(1)) |-> dir_prev);

  assert_idx_down_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_delta == '1) |-> !dir_prev);

  assert_idx_single_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_delta == '0 || idx_delta == IDX_W'(1) || idx_delta == '1));

  assert_hold_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> (pos_delta == '0));

endmodule

bind qenc_counter qenc_counter_chk #(.POS_W(POS_W), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_src      (cfg_src),
  .cfg_pos_mode (cfg_pos_mode),
  .lim_lo       (lim_lo),
  .lim_hi       (lim_hi),
  .pos_count    (pos_count),
  .idx_count    (idx_count),
  .dir_up       (dir_up),
  .err_flag     (err_flag)
);

// File: tb/sim_qenc_counter.sv
`timescale 1ns/1ps
module sim_qenc_counter;

  localparam int POS_W = 16;
  localparam int IDX_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
  logic [1:0] cfg_src = 2'b00;
  logic [2:0] cfg_pos_mode = 3'b000;
  logic cfg_invert = 1'b0;
  logic signed [POS_W-1:0] lim_lo = '0, lim_hi = '0;
  logic signed [POS_W-1:0] pos_count;
  logic signed [IDX_W-1:0] idx_count;
  logic dir_up, err_flag;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  qenc_counter #(.POS_W(POS_W), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .cfg_src(cfg_src), .cfg_pos_mode(cfg_pos_mode), .cfg_invert(cfg_invert),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .pos_count(pos_count),
    .idx_count(idx_count), .dir_up(dir_up), .err_flag(err_flag)
  );

  task automatic check(input string req, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {enc_a, enc_b, enc_idx} = 3'b000;
    cfg_src = 2'b00; cfg_pos_mode = 3'b000; cfg_invert = 1'b0;
    lim_lo = '0; lim_hi = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Gray sequence for upward motion: 00 -> 10 -> 11 -> 01 -> 00 ({A,B})
  task automatic phys_up();
    @(negedge clk);
    case ({enc_a, enc_b})
      2'b00: {enc_a, enc_b} = 2'b10;
      2'b10: {enc_a, enc_b} = 2'b11;
      2'b11: {enc_a, enc_b} = 2'b01;
      default: {enc_a, enc_b} = 2'b00;
    endcase
    settle();
  endtask

  task automatic phys_dn();
    @(negedge clk);
    case ({enc_a, enc_b})
      2'b00: {enc_a, enc_b} = 2'b01;
      2'b01: {enc_a, enc_b} = 2'b11;
      2'b11: {enc_a, enc_b} = 2'b10;
      default: {enc_a, enc_b} = 2'b00;
    endcase
    settle();
  endtask

  task automatic pulse_idx();
    @(negedge clk); enc_idx = 1'b1; settle();
    enc_idx = 1'b0; settle();
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 pos", int'(pos_count), 0);
    check("R1 idx", int'(idx_count), 0);
    check("R1 dir", int'(dir_up), 1);
    check("R1 err", int'(err_flag), 0);
  endtask

  task automatic t_quad();
    do_reset();
    // latency: new value on the third rising edge after the change
    @(negedge clk); {enc_a, enc_b} = 2'b10;
    repeat (2) @(negedge clk);
    check("R2 latency before", int'(pos_count), 0);
    @(negedge clk);
    check("R2 latency at third edge", int'(pos_count), 1);
    settle();
    for (int i = 0; i < 7; i++) phys_up();
    check("R2 up count", int'(pos_count), 8);
    check("R2 dir up", int'(dir_up), 1);
    for (int i = 0; i < 3; i++) phys_dn();
    check("R2 down count", int'(pos_count), 5);
    check("R2 dir down", int'(dir_up), 0);
  endtask

  task automatic t_illegal();
    do_reset();
    phys_up();
    @(negedge clk); {enc_a, enc_b} = 2'b01;
    settle();
    check("R3 no count", int'(pos_count), 1);
    check("R3 err set", int'(err_flag), 1);
    phys_up();
    check("R3 legal after", int'(pos_count), 2);
    check("R3 err sticky", int'(err_flag), 1);
  endtask

  task automatic t_polarity();
    do_reset();
    cfg_invert = 1'b1;
    for (int i = 0; i < 3; i++) phys_up();
    check("R4 inverted up", int'(pos_count), -3);
    check("R4 dir", int'(dir_up), 0);
    phys_dn();
    check("R4 inverted down", int'(pos_count), -2);
  endtask

  task automatic t_index();
    do_reset();
    phys_dn();
    pulse_idx();
    check("R8 idx down", int'(idx_count), -1);
    phys_up();
    pulse_idx();
    pulse_idx();
    check("R7 idx up", int'(idx_count), 1);
  endtask

  task automatic t_modulo();
    do_reset();
    cfg_pos_mode = 3'b110; lim_lo = -16'sd3; lim_hi = 16'sd2;
    phys_up(); phys_up();
    check("R5 reach hi", int'(pos_count), 2);
    phys_up();
    check("R5 wrap to lo", int'(pos_count), -3);
    phys_dn();
    check("R6 wrap to hi", int'(pos_count), 2);
    cfg_invert = 1'b1;
    for (int i = 0; i < 5; i++) phys_up();
    check("R6 inverted reach lo", int'(pos_count), -3);
    phys_up();
    check("R6 inverted wrap to hi", int'(pos_count), 2);
    phys_dn();
    check("R5 inverted wrap to lo", int'(pos_count), -3);
  endtask

  task automatic t_free_wrap();
    do_reset();
    phys_dn();
    check("R12 wrap all ones", int'(pos_count[POS_W-1:0]), 16'hFFFF);
  endtask

  task automatic t_extclk();
    do_reset();
    cfg_src = 2'b01;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); enc_a = 1'b1; settle();
      enc_a = 1'b0; settle();
    end
    check("R9 up count", int'(pos_count), 3);
    @(negedge clk); enc_b = 1'b1; settle();
    check("R9 B alone", int'(pos_count), 3);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); enc_a = 1'b1; settle();
      enc_a = 1'b0; settle();
    end
    check("R9 down count", int'(pos_count), 1);
    check("R9 dir", int'(dir_up), 0);
  endtask

  task automatic t_timer_hold();
    do_reset();
    @(negedge clk); cfg_src = 2'b10;
    repeat (10) @(negedge clk);
    cfg_src = 2'b11;
    check("R10 timer count", int'(pos_count), 10);
    @(negedge clk); enc_a = 1'b1; settle();
    enc_b = 1'b1; settle();
    repeat (5) @(negedge clk);
    check("R11 hold", int'(pos_count), 10);
  endtask

  initial begin
    t_reset();
    t_quad();
    t_illegal();
    t_polarity();
    t_index();
    t_modulo();
    t_free_wrap();
    t_extclk();
    t_timer_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule